// File: doc/BRIEF.md
# Phase-Correct PWM Timer

This block is an 8-bit dual-slope timer/counter that drives a single PWM output whose edges sit symmetrically about the counter's bottom value. A prescaler divides the system clock by a selectable factor and produces a one-cycle enable. On each enable the counter steps up from 0 to 255, turns around, and steps back down to 0, so one PWM period lasts 510 enables. Everything runs on the one system clock, and the divided tick is used only as an enable.

The output level comes from a match between the counter and a double-buffered compare value. A newly written compare value takes effect only when the counter reaches its top. The block keeps the waveform symmetric in two situations: when the compare value leaves the top value, and when the counter is loaded above the compare value, which skips the match on the way up. In both cases the output is forced to its up-match level at the top, without waiting for a match. A sticky flag marks each arrival at bottom. A polarity input inverts the output.

Top module: `pcpwm_timer`

## Requirements
- R1: `clkSel` picks the divide factor: code 1 gives 1, code 2 gives 8, code 3 gives 64, code 4 gives 256 and code 5 gives 1024. The counter then steps exactly once every N clock cycles. Codes 0, 6 and 7 stop the counter.
- R2: The count goes 0,1,…,255,254,…,1,0,1,… and holds each end value for one step, so the period is 510 steps. `countDown` is 1 when the count is 255 and 0 when the count is 0.
- R3: `ovfFlag` is set on the step that brings the count to 0. It stays set until `ovfClear` is high for a cycle. A set and a clear in the same cycle leave the flag set.
- R4: `cmpWrite` stores `cmpData` in a buffer. The output logic uses the buffered value only from the step at which the count reaches 255.
- R5: With `invertMode` low and a compare value C from 1 to 254, the output goes low when the count reaches C while counting up, and goes high when the count reaches C while counting down. It is therefore high for 2·C of the 510 steps.
- R6: With `invertMode` low, a compare value of 0 gives a constant low output and a compare value of 255 gives a constant high output.
- R7: With `invertMode` high, `pwmOut` is the complement of the non-inverted level in every case, including the cases in R6.
- R8: On the step that reaches 255, the output takes its up-match level: low, unless the new compare value is 255. This holds even when no match occurred, for example when the compare value leaves 255 or the up-going match was skipped.
- R9: `cntWrite` loads `cntData` into the count and takes priority over a step. The direction becomes up, or down when 255 is loaded. A load does not change the output.
- R10: A synchronous `rst` clears the count, the prescaler, the flag, the compare values and the output level, and sets the direction to up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clkSel | input | 3 | Divide-factor select code |
| invertMode | input | 1 | 1 inverts the output polarity |
| cmpWrite | input | 1 | Stores `cmpData` into the compare buffer |
| cmpData | input | 8 | New compare value |
| cntWrite | input | 1 | Loads `cntData` into the counter |
| cntData | input | 8 | Value to load into the counter |
| ovfClear | input | 1 | Clears the bottom flag |
| pwmOut | output | 1 | PWM waveform |
| count | output | 8 | Current counter value |
| countDown | output | 1 | Current direction, 1 = counting down |
| ovfFlag | output | 1 | Sticky flag, set when the count reaches bottom |

## Verification
A step, a load, a flag clear and the output change caused by a match all become visible one clock edge after the cycle in which they occur. `pwmOut` follows `invertMode` within the same cycle. A compare write only changes behaviour from the next arrival at 255. The bench therefore waits for that arrival before it compares any output levels against the new value. All outputs are sampled on falling edges, half a cycle after the edge that updated them. The bench locates each checkpoint by watching for the count and direction to reach a given value. With divide-by-one, the step interval and the 510-cycle period are counted in clock cycles.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;
  localparam int CNT_W   = 8;
  localparam int SEL_W   = 3;
  localparam int PRESC_W = 10;

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t CNT_TOP = '1;
  localparam cnt_t CNT_BOT = '0;

  typedef struct packed {
    logic advance;
    logic goingUp;
    cnt_t nextCount;
  } strobe_t;

  function automatic logic selRuns(input logic [SEL_W-1:0] sel);
    return (sel >= SEL_W'(1)) && (sel <= SEL_W'(5));
  endfunction

  function automatic logic [PRESC_W-1:0] divLimit(input logic [SEL_W-1:0] sel);
    int shift;
    case (sel)
      SEL_W'(2): shift = 3;
      SEL_W'(3): shift = 6;
      SEL_W'(4): shift = 8;
      SEL_W'(5): shift = 10;
      default:   shift = 0;
    endcase
    return PRESC_W'((1 << shift) - 1);
  endfunction
endpackage

// File: rtl/pcpwm_ctrl.sv
module pcpwm_ctrl
  import pcpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             cntWrite,
  input  cnt_t             cntData,
  output cnt_t             count,
  output logic             countDown,
  output strobe_t          strobe
);
  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] limit;
  logic running;
  logic tick;
  cnt_t nextCount;
  logic nextDown;

  assign running = selRuns(clkSel);
  assign limit   = divLimit(clkSel);
  assign tick    = running && (presc >= limit);

  always_ff @(posedge clk) begin
    if (rst || !running) presc <= '0;
    else if (tick)       presc <= '0;
    else                 presc <= presc + 1'b1;
  end

  always_comb begin
    nextCount = countDown ? count - 1'b1 : count + 1'b1;
    nextDown  = countDown;
    if (!countDown && nextCount == CNT_TOP) nextDown = 1'b1;
    if (countDown && nextCount == CNT_BOT)  nextDown = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= CNT_BOT;
      countDown <= 1'b0;
    end else if (cntWrite) begin
      count     <= cntData;
      countDown <= (cntData == CNT_TOP);
    end else if (tick) begin
      count     <= nextCount;
      countDown <= nextDown;
    end
  end

  assign strobe.advance   = tick && !cntWrite;
  assign strobe.goingUp   = !countDown;
  assign strobe.nextCount = nextCount;

  p_hold_no_tick_r1: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cntWrite) |=> ($stable(count) && $stable(countDown)));

  p_top_down_r2: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_TOP) |-> countDown);

  p_bottom_up_r2: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_BOT) |-> !countDown);

  p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.advance |=> ((count == cnt_t'($past(count) + 1'b1)) ||
                        (count == cnt_t'($past(count) - 1'b1))));
endmodule

// File: rtl/pcpwm_dpath.sv
module pcpwm_dpath
  import pcpwm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  strobe_t strobe,
  input  logic    cmpWrite,
  input  cnt_t    cmpData,
  input  logic    invertMode,
  input  logic    ovfClear,
  output logic    pwmOut,
  output logic    ovfFlag
);
  cnt_t cmpBuf;
  cnt_t cmpActive;
  logic level;
  logic reachTop;
  logic reachBottom;
  logic matchHit;

  assign reachTop    = strobe.advance && (strobe.nextCount == CNT_TOP);
  assign reachBottom = strobe.advance && (strobe.nextCount == CNT_BOT);
  assign matchHit    = strobe.advance && (strobe.nextCount == cmpActive);

  always_ff @(posedge clk) begin
    if (rst)           cmpBuf <= CNT_BOT;
    else if (cmpWrite) cmpBuf <= cmpData;
  end

  always_ff @(posedge clk) begin
    if (rst)           cmpActive <= CNT_BOT;
    else if (reachTop) cmpActive <= cmpBuf;
  end

  always_ff @(posedge clk) begin
    if (rst)              level <= 1'b0;
    else if (reachTop)    level <= (cmpBuf == CNT_TOP);
    else if (reachBottom) level <= (cmpActive != CNT_BOT);
    else if (matchHit)    level <= !strobe.goingUp;
  end

  always_ff @(posedge clk) begin
    if (rst)              ovfFlag <= 1'b0;
    else if (reachBottom) ovfFlag <= 1'b1;
    else if (ovfClear)    ovfFlag <= 1'b0;
  end

  assign pwmOut = level ^ invertMode;

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (ovfFlag && !ovfClear) |=> ovfFlag);

  p_flag_on_bottom_r3: assert property (@(posedge clk) disable iff (rst)
    reachBottom |=> ovfFlag);

  p_cmp_held_r4: assert property (@(posedge clk) disable iff (rst)
    !reachTop |=> $stable(cmpActive));

  p_flat_low_r6: assert property (@(posedge clk) disable iff (rst)
    (cmpActive == CNT_BOT) |-> !level);

  p_flat_high_r6: assert property (@(posedge clk) disable iff (rst)
    (cmpActive == CNT_TOP) |-> level);

  p_top_level_r8: assert property (@(posedge clk) disable iff (rst)
    reachTop |=> (level == (cmpActive == CNT_TOP)));
endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
  import pcpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             invertMode,
  input  logic             cmpWrite,
  input  logic [CNT_W-1:0] cmpData,
  input  logic             cntWrite,
  input  logic [CNT_W-1:0] cntData,
  input  logic             ovfClear,
  output logic             pwmOut,
  output logic [CNT_W-1:0] count,
  output logic             countDown,
  output logic             ovfFlag
);
  strobe_t strobe;

  pcpwm_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .clkSel   (clkSel),
    .cntWrite (cntWrite),
    .cntData  (cntData),
    .count    (count),
    .countDown(countDown),
    .strobe   (strobe)
  );

  pcpwm_dpath i_dpath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .cmpWrite  (cmpWrite),
    .cmpData   (cmpData),
    .invertMode(invertMode),
    .ovfClear  (ovfClear),
    .pwmOut    (pwmOut),
    .ovfFlag   (ovfFlag)
  );
endmodule

// File: tb/test_pcpwm_timer.sv
module test_pcpwm_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] clkSel = 3'd1;
  logic       invertMode = 1'b0;
  logic       cmpWrite = 1'b0;
  logic [7:0] cmpData = 8'd0;
  logic       cntWrite = 1'b0;
  logic [7:0] cntData = 8'd0;
  logic       ovfClear = 1'b0;
  logic       pwmOut;
  logic [7:0] count;
  logic       countDown;
  logic       ovfFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  pcpwm_timer i_pcpwm_timer (
    .clk(clk), .rst(rst), .clkSel(clkSel), .invertMode(invertMode),
    .cmpWrite(cmpWrite), .cmpData(cmpData), .cntWrite(cntWrite),
    .cntData(cntData), .ovfClear(ovfClear), .pwmOut(pwmOut),
    .count(count), .countDown(countDown), .ovfFlag(ovfFlag)
  );

  always #5 clk = ~clk;

  // {invert, compare, expected high samples per 510-step period}
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 8'd100, 10'd200},
    {1'b1, 8'd100, 10'd310},
    {1'b0, 8'd0,   10'd0},
    {1'b1, 8'd0,   10'd510},
    {1'b0, 8'd255, 10'd510},
    {1'b1, 8'd255, 10'd0},
    {1'b0, 8'd1,   10'd2},
    {1'b0, 8'd254, 10'd508}
  };

  function automatic logic expOut(input logic [7:0] c, input logic d,
                                  input logic [7:0] cmp, input logic inv);
    logic b;
    if (cmp == 8'd255)    b = 1'b1;
    else if (cmp == 8'd0) b = 1'b0;
    else                  b = d ? (c <= cmp) : (c < cmp);
    return b ^ inv;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCount(input logic [7:0] v, input logic d);
    int guard = 0;
    while (!(count == v && countDown == d) && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 3000) check(1'b0, "sync: count never reached", int'(count), int'(v));
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic writeCmp(input logic [7:0] v);
    cmpWrite = 1'b1; cmpData = v;
    @(negedge clk);
    cmpWrite = 1'b0;
  endtask

  task automatic loadCount(input logic [7:0] v);
    cntWrite = 1'b1; cntData = v;
    @(negedge clk);
    cntWrite = 1'b0;
  endtask

  task automatic pulseClear();
    ovfClear = 1'b1;
    @(negedge clk);
    ovfClear = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finishRun();
    end
  end

  initial begin
    int cyc;
    int cyc2;
    int highs;
    int mism;
    int tops;
    logic [7:0] c0;
    logic [7:0] vc;
    logic vi;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: state right after reset
    check(count == 8'd0 && !countDown, "R10 reset count/dir", int'(count), 0);
    check(!ovfFlag && !pwmOut, "R10 reset flag/out", int'({ovfFlag, pwmOut}), 0);

    // R1: divide factors per select code
    for (int s = 1; s <= 5; s++) begin
      int n;
      n = (s == 1) ? 1 : (s == 2) ? 8 : (s == 3) ? 64 : (s == 4) ? 256 : 1024;
      clkSel = 3'(s);
      doReset();
      cyc = 0;
      while (count == 8'd0 && cyc < 3000) begin @(negedge clk); cyc++; end
      c0 = count;
      cyc2 = 0;
      while (count == c0 && cyc2 < 3000) begin @(negedge clk); cyc2++; end
      check(cyc == n && cyc2 == n, "R1 step interval", cyc2, n);
    end
    for (int s = 0; s < 8; s += 6) begin
      clkSel = 3'(s);
      doReset();
      repeat (50) @(negedge clk);
      check(count == 8'd0, "R1 stopped select holds count", int'(count), 0);
    end
    clkSel = 3'd7;
    repeat (20) @(negedge clk);
    check(count == 8'd0, "R1 select 7 holds count", int'(count), 0);

    // R2: period and turnaround
    clkSel = 3'd1;
    doReset();
    waitCount(8'd128, 1'b1);
    waitCount(8'd0, 1'b0);
    cyc = 0; tops = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (count == 8'd255) begin
        tops++;
        if (!countDown) tops += 100;
      end
    end while (count != 8'd0 && cyc < 600);
    check(cyc == 510, "R2 period in steps", cyc, 510);
    check(tops == 1, "R2 top held one step, direction down", tops, 1);
    waitCount(8'd255, 1'b1);
    @(negedge clk);
    check(count == 8'd254 && countDown, "R2 turn after top", int'(count), 254);

    // R3: bottom flag
    waitCount(8'd100, 1'b1);
    pulseClear();
    check(!ovfFlag, "R3 clear", int'(ovfFlag), 0);
    waitCount(8'd1, 1'b1);
    check(!ovfFlag, "R3 not set before bottom", int'(ovfFlag), 0);
    ovfClear = 1'b1;
    @(negedge clk);
    ovfClear = 1'b0;
    check(count == 8'd0 && ovfFlag, "R3 set at bottom wins over clear", int'(ovfFlag), 1);
    repeat (20) @(negedge clk);
    check(ovfFlag, "R3 sticky", int'(ovfFlag), 1);
    pulseClear();
    check(!ovfFlag, "R3 clear after set", int'(ovfFlag), 0);

    // R5 R6 R7: table of compare/polarity vectors over one full period
    for (int i = 0; i < 8; i++) begin
      vi = VEC[i][18];
      vc = VEC[i][17:10];
      invertMode = vi;
      writeCmp(vc);
      waitCount(8'd254, 1'b0);
      waitCount(8'd255, 1'b1);
      highs = 0; mism = 0;
      for (int k = 0; k < 510; k++) begin
        if (pwmOut) highs++;
        if (pwmOut !== expOut(count, countDown, vc, vi)) mism++;
        @(negedge clk);
      end
      check(mism == 0, "R5 R6 R7 level per step", mism, 0);
      check(highs == int'(VEC[i][9:0]), "R5 R6 R7 high steps per period", highs, int'(VEC[i][9:0]));
    end
    invertMode = 1'b0;

    // R4: buffered compare applies only from the top
    writeCmp(8'd100);
    waitCount(8'd254, 1'b0);
    waitCount(8'd255, 1'b1);
    waitCount(8'd20, 1'b0);
    writeCmp(8'd50);
    waitCount(8'd60, 1'b0);
    check(pwmOut, "R4 old compare still in use", int'(pwmOut), 1);
    waitCount(8'd60, 1'b1);
    check(!pwmOut, "R4 new compare after top", int'(pwmOut), 0);
    waitCount(8'd50, 1'b1);
    check(pwmOut, "R4 new compare match down", int'(pwmOut), 1);

    // R8: compare leaving 255 forces the up-match level at the top
    writeCmp(8'd255);
    waitCount(8'd254, 1'b0);
    waitCount(8'd255, 1'b1);
    waitCount(8'd50, 1'b0);
    writeCmp(8'd100);
    waitCount(8'd254, 1'b0);
    check(pwmOut, "R8 high before top", int'(pwmOut), 1);
    @(negedge clk);
    check(count == 8'd255 && !pwmOut, "R8 low at top without match", int'(pwmOut), 0);
    waitCount(8'd100, 1'b1);
    check(pwmOut, "R8 down match after leaving 255", int'(pwmOut), 1);

    // R9: load above compare skips the up match; R8 restores symmetry
    waitCount(8'd50, 1'b0);
    check(pwmOut, "R9 high before load", int'(pwmOut), 1);
    loadCount(8'd200);
    check(count == 8'd200 && !countDown && pwmOut, "R9 load keeps output", int'(count), 200);
    waitCount(8'd254, 1'b0);
    check(pwmOut, "R9 missed up match", int'(pwmOut), 1);
    @(negedge clk);
    check(count == 8'd255 && !pwmOut, "R8 R9 forced low at top", int'(pwmOut), 0);
    waitCount(8'd10, 1'b0);
    loadCount(8'd255);
    check(count == 8'd255 && countDown, "R9 load 255 turns down", int'(countDown), 1);
    @(negedge clk);
    check(count == 8'd254, "R9 step after loading 255", int'(count), 254);

    // R10: reset in mid-run
    waitCount(8'd0, 1'b0);
    waitCount(8'd77, 1'b1);
    invertMode = 1'b1;
    doReset();
    check(count == 8'd0 && !countDown && !ovfFlag, "R10 mid-run reset", int'(count), 0);
    check(pwmOut, "R10 reset level inverted", int'(pwmOut), 1);

    done = 1'b1;
    finishRun();
  end
endmodule